// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave

This block is a byte-wide memory that answers as a slave on an open-drain two-wire bus. The bus clock and data lines come in as plain inputs. The block's only way to drive the data line is an active-high pull-down enable. A faster system clock samples both lines through short synchronisers. Start, repeated start and stop are recognised as data-line edges while the bus clock is high. The storage is an internal 512-byte register file, cleared by reset.

A master writes one byte by sending, in order, a device byte with the direction bit at 0, a word address and a data byte, and then ends with a stop. The byte lands in the array when the stop arrives.

Reads use a persistent address counter, which always points one past the last byte touched. A read-direction device byte returns the byte at the counter with no address phase. For a random read, the master first performs a write with only the word address, so no data is stored, and then issues a repeated start. If the master acknowledges a returned byte, the slave streams the next one. If it does not, the slave lets go of the line and waits for a stop.

Top module: `e2w_eeprom_slave`

## Requirements
- R1: After reset the pull-down enable is low, the address counter is 0 and every byte of the array reads 0.
- R2: A device byte is accepted when its upper six bits equal DEV_ID (default 6'b101000). Bit 1 is the page bit and bit 0 selects the direction: 1 for read, 0 for write. The slave acknowledges an accepted device byte by pulling SDA low during the ninth clock.
- R3: After a device byte that does not match, the slave leaves SDA released on every clock until the next start condition. Nothing in the array changes.
- R4: A byte write is start, device byte with direction 0, word address, data byte, stop. Each of the three bytes is acknowledged. The data is stored at the stop, and the counter then equals the written address plus one.
- R5: A current-address read returns the byte at the counter, most significant bit first, and leaves the counter one higher. The page bit of a read device byte does not affect the address.
- R6: A word-address write followed by a repeated start and a read device byte returns the byte at that word address.
- R7: When the master pulls SDA low on the ninth clock after a read byte, the slave sends the byte at the next address.
- R8: When SDA is high on the ninth clock after a read byte, the slave releases SDA and stays released until a stop or start condition.
- R9: The counter wraps from 511 to 0, for both a write and a sequential read.
- R10: The pull-down enable changes only while the synchronised bus clock is low.
- R11: When a word address is loaded, the page bit of that transaction's device byte becomes address bit 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen on the wire |
| sda_i | input | 1 | Bus data line as seen on the wire |
| sda_pull_o | output | 1 | 1 pulls the data line low; 0 releases it |

## Verification
Both lines pass through a two-flop synchroniser and an edge register. The slave therefore reacts to a bus-clock falling edge three to four system cycles later, with a registered pull-down change. The bench keeps the bus clock low for 20 system cycles before any rising edge and reads SDA in the middle of the 20-cycle high phase. Every acknowledge and data bit is therefore sampled long after the slave has settled, and long before it may move again. Bytes returned by reads are compared in the order they were requested against a behavioural model of the array and counter.

// File: rtl/e2w_pkg.sv
package e2w_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_ACK,
    ST_TX,
    ST_MACK
  } e2w_state_t;

  typedef enum logic [1:0] {
    RK_DEV,
    RK_WORD,
    RK_DATA
  } e2w_rxkind_t;
endpackage

// File: rtl/e2w_busin.sv
module e2w_busin #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_ff, sda_ff;
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[STAGES-2:0], scl_i};
      sda_ff <= {sda_ff[STAGES-2:0], sda_i};
      scl_q  <= scl_ff[STAGES-1];
      sda_q  <= sda_ff[STAGES-1];
    end
  end

  assign scl_s     = scl_ff[STAGES-1];
  assign sda_s     = sda_ff[STAGES-1];
  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_det = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/e2w_regfile.sv
module e2w_regfile #(
  parameter int AW = 9,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (we) begin
      mem[waddr] <= wdata;
    end
  end

  assign rdata = mem[raddr];

  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> mem[$past(waddr)] == $past(wdata)); // R4
endmodule

// File: rtl/e2w_eeprom_slave.sv
module e2w_eeprom_slave
  import e2w_pkg::*;
#(
  parameter int         ADDR_W      = 9,
  parameter logic [5:0] DEV_ID      = 6'b101000,
  parameter int         SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_pull_o
);
  localparam int BYTE_W = 8;

  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;

  e2w_busin #(.STAGES(SYNC_STAGES)) u_busin (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .scl_s     (scl_s),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  e2w_state_t          st;
  e2w_rxkind_t         kind;
  logic [BYTE_W-1:0]   shreg, wr_data, mem_rd;
  logic [3:0]          bitcnt;
  logic [ADDR_W-1:0]   ctr, wr_addr, ld_addr;
  logic                page, rw, mack, wr_pend, pull;
  logic                mem_we;

  assign mem_we     = stop_det & wr_pend;
  assign ld_addr    = ADDR_W'({page, shreg});
  assign sda_pull_o = pull;

  e2w_regfile #(.AW(ADDR_W), .DW(BYTE_W)) u_regfile (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (mem_we),
    .waddr (wr_addr),
    .wdata (wr_data),
    .raddr (ctr),
    .rdata (mem_rd)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      kind    <= RK_DEV;
      shreg   <= '0;
      wr_data <= '0;
      bitcnt  <= '0;
      ctr     <= '0;
      wr_addr <= '0;
      page    <= 1'b0;
      rw      <= 1'b0;
      mack    <= 1'b0;
      wr_pend <= 1'b0;
      pull    <= 1'b0;
    end else if (start_det) begin
      st      <= ST_RX;
      kind    <= RK_DEV;
      bitcnt  <= '0;
      pull    <= 1'b0;
      wr_pend <= 1'b0;
    end else if (stop_det) begin
      if (wr_pend) ctr <= wr_addr + ADDR_W'(1);
      wr_pend <= 1'b0;
      pull    <= 1'b0;
      st      <= ST_IDLE;
    end else begin
      unique case (st)
        ST_RX: begin
          if (scl_rise && bitcnt < 4'd8) begin
            shreg  <= {shreg[BYTE_W-2:0], sda_s};
            bitcnt <= bitcnt + 4'd1;
          end else if (scl_fall && bitcnt == 4'd8) begin
            unique case (kind)
              RK_DEV: begin
                if (shreg[7:2] == DEV_ID) begin
                  page <= shreg[1];
                  rw   <= shreg[0];
                  pull <= 1'b1;
                  st   <= ST_ACK;
                end else begin
                  st <= ST_IDLE;
                end
              end
              RK_WORD: begin
                wr_addr <= ld_addr;
                ctr     <= ld_addr;
                pull    <= 1'b1;
                st      <= ST_ACK;
              end
              default: begin
                wr_data <= shreg;
                wr_pend <= 1'b1;
                pull    <= 1'b1;
                st      <= ST_ACK;
              end
            endcase
          end
        end
        ST_ACK: begin
          if (scl_fall) begin
            bitcnt <= '0;
            if (kind == RK_DEV && rw) begin
              pull   <= ~mem_rd[7];
              shreg  <= {mem_rd[BYTE_W-2:0], 1'b0};
              bitcnt <= 4'd1;
              ctr    <= ctr + ADDR_W'(1);
              st     <= ST_TX;
            end else begin
              pull <= 1'b0;
              if (kind == RK_DEV) begin
                kind <= RK_WORD;
                st   <= ST_RX;
              end else if (kind == RK_WORD) begin
                kind <= RK_DATA;
                st   <= ST_RX;
              end else begin
                st <= ST_IDLE;
              end
            end
          end
        end
        ST_TX: begin
          if (scl_fall) begin
            if (bitcnt < 4'd8) begin
              pull   <= ~shreg[7];
              shreg  <= {shreg[BYTE_W-2:0], 1'b0};
              bitcnt <= bitcnt + 4'd1;
            end else begin
              pull <= 1'b0;
              st   <= ST_MACK;
            end
          end
        end
        ST_MACK: begin
          if (scl_rise) mack <= ~sda_s;
          if (scl_fall) begin
            if (mack) begin
              pull   <= ~mem_rd[7];
              shreg  <= {mem_rd[BYTE_W-2:0], 1'b0};
              bitcnt <= 4'd1;
              ctr    <= ctr + ADDR_W'(1);
              st     <= ST_TX;
            end else begin
              st <= ST_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  AST_PULL_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_pull_o) |-> !scl_s); // R10
  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE) |-> !sda_pull_o); // R3
  AST_STOP_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> (st == ST_IDLE)); // R8
  AST_CTR_AFTER_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> ctr == $past(wr_addr) + ADDR_W'(1)); // R9
  AST_BITCNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    bitcnt <= 4'd8); // R2
endmodule

// File: tb/e2w_eeprom_slave_bench.sv
module e2w_eeprom_slave_bench;
  localparam int Q = 10;
  localparam logic [5:0] DID = 6'b101000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic sda_m = 1'b1;
  logic sda_pull;
  logic sda_line;

  assign sda_line = sda_m & ~sda_pull;

  always #5 clk = ~clk;

  e2w_eeprom_slave u_e2w_eeprom_slave (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_i      (scl),
    .sda_i      (sda_line),
    .sda_pull_o (sda_pull)
  );

  int n_cmp = 0;
  int n_bad = 0;
  int r10_viol = 0;
  logic [7:0] mdl [512];
  int mctr = 0;
  logic [7:0] exp_q[$];
  logic [7:0] got_q[$];
  string req_q[$];

  task automatic chk(string req, int got, int exp);
    n_cmp++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, got, exp);
    end
  endtask

  // monitor: pop read results and compare with expected
  initial begin
    forever begin
      @(negedge clk);
      while (got_q.size() > 0 && exp_q.size() > 0) begin
        chk(req_q.pop_front(), int'(got_q.pop_front()), int'(exp_q.pop_front()));
      end
    end
  end

  // R10: pull-down may only move while SCL is low
  initial begin
    logic prev;
    prev = 1'b0;
    forever begin
      @(negedge clk);
      if (rst_n && sda_pull != prev && scl) r10_viol++;
      prev = sda_pull;
    end
  end

  task automatic wcyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bit_tx(input logic b);
    sda_m = b; wcyc(Q); scl = 1'b1; wcyc(2*Q); scl = 1'b0; wcyc(Q);
  endtask

  task automatic bit_rx(output logic b);
    sda_m = 1'b1; wcyc(Q); scl = 1'b1; wcyc(Q); b = sda_line; wcyc(Q); scl = 1'b0; wcyc(Q);
  endtask

  task automatic bus_start;
    sda_m = 1'b1; wcyc(Q); scl = 1'b1; wcyc(Q); sda_m = 1'b0; wcyc(Q); scl = 1'b0; wcyc(Q);
  endtask

  task automatic bus_stop;
    sda_m = 1'b0; wcyc(Q); scl = 1'b1; wcyc(Q); sda_m = 1'b1; wcyc(Q);
  endtask

  task automatic send_byte(input logic [7:0] d, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) bit_tx(d[i]);
    bit_rx(b);
    ack = ~b;
  endtask

  task automatic recv_byte(output logic [7:0] d, input logic give_ack);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      bit_rx(b);
      d[i] = b;
    end
    bit_tx(~give_ack);
  endtask

  task automatic rd_body(int n, string req);
    logic ack;
    logic [7:0] d;
    send_byte({DID, 1'b0, 1'b1}, ack);
    chk("R2 read device ack", int'(ack), 1);
    for (int i = 0; i < n; i++) begin
      exp_q.push_back(mdl[mctr]);
      req_q.push_back(req);
      mctr = (mctr + 1) % 512;
      recv_byte(d, i < n - 1);
      got_q.push_back(d);
    end
    bus_stop;
  endtask

  task automatic do_write(logic pg, logic [7:0] word, logic [7:0] data);
    logic ack;
    bus_start;
    send_byte({DID, pg, 1'b0}, ack); chk("R2 write device ack", int'(ack), 1);
    send_byte(word, ack);            chk("R4 word ack", int'(ack), 1);
    send_byte(data, ack);            chk("R4 data ack", int'(ack), 1);
    bus_stop;
    mdl[{pg, word}] = data;
    mctr = (int'({pg, word}) + 1) % 512;
  endtask

  task automatic do_read(int n, string req);
    bus_start;
    rd_body(n, req);
  endtask

  task automatic do_rand(logic pg, logic [7:0] word, int n, string req);
    logic ack;
    bus_start;
    send_byte({DID, pg, 1'b0}, ack); chk("R6 dummy device ack", int'(ack), 1);
    send_byte(word, ack);            chk("R6 dummy word ack", int'(ack), 1);
    mctr = int'({pg, word});
    bus_start;
    rd_body(n, req);
  endtask

  task automatic finish_run;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
    finish_run;
  end

  initial begin
    logic ack;
    logic [7:0] d;
    int highs;
    for (int i = 0; i < 512; i++) mdl[i] = 8'h00;
    wcyc(5);
    chk("R1 pull released in reset", int'(sda_pull), 0);
    rst_n = 1'b1;
    wcyc(5);
    chk("R1 pull released after reset", int'(sda_pull), 0);

    do_read(1, "R1 R5 current read after reset");
    do_write(1'b0, 8'h05, 8'hA5);
    do_read(1, "R4 R5 counter after write");
    do_rand(1'b0, 8'h05, 1, "R6 random read");

    do_write(1'b1, 8'h10, 8'h3C);
    do_rand(1'b1, 8'h10, 1, "R11 page 1 read");
    do_rand(1'b0, 8'h10, 1, "R11 page 0 read");

    do_write(1'b0, 8'h20, 8'h11);
    do_write(1'b0, 8'h21, 8'h22);
    do_write(1'b0, 8'h22, 8'h33);
    do_rand(1'b0, 8'h20, 3, "R7 sequential read");
    do_read(1, "R7 counter after sequential");

    do_write(1'b0, 8'h00, 8'h99);
    do_write(1'b1, 8'hFE, 8'h5A);
    do_write(1'b1, 8'hFF, 8'h77);
    do_read(1, "R9 wrap after write");
    do_rand(1'b1, 8'hFE, 3, "R9 wrap in sequential read");

    // R3: non-matching device byte, whole write attempt ignored
    bus_start;
    send_byte(8'h92, ack); chk("R3 no ack on mismatch", int'(ack), 0);
    send_byte(8'h05, ack); chk("R3 released after mismatch", int'(ack), 0);
    send_byte(8'hFF, ack); chk("R3 released on data", int'(ack), 0);
    bus_stop;
    do_rand(1'b0, 8'h05, 1, "R3 array unchanged");

    // R8: NACK then extra clocks, line must stay high
    mctr = 5;
    bus_start;
    send_byte({DID, 1'b0, 1'b0}, ack);
    send_byte(8'h05, ack);
    bus_start;
    send_byte({DID, 1'b0, 1'b1}, ack);
    chk("R8 read device ack", int'(ack), 1);
    exp_q.push_back(mdl[5]); req_q.push_back("R8 byte before nack");
    recv_byte(d, 1'b0);
    got_q.push_back(d);
    mctr = 6;
    highs = 0;
    for (int i = 0; i < 9; i++) begin
      logic b;
      bit_rx(b);
      if (b) highs++;
    end
    chk("R8 released after nack", highs, 9);
    bus_stop;
    do_read(1, "R8 counter after nack");

    wcyc(20);
    while (got_q.size() > 0) wcyc(1);
    chk("R10 pull changes with SCL high", r10_viol, 0);
    finish_run;
  end
endmodule